// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block sits on the device side of a byte-wide parallel flash. It receives bus write cycles as one-clock strobes, each with an address and a data byte. It tracks the multi-cycle unlock sequences that carry commands. From them it keeps a mode register that the rest of the device reads: read array, identification, query, program, chip erase or sector erase. When a sequence completes it issues a one-clock start strobe, together with the address and data it captured.

Every command except reset, query entry and resume starts with the same two unlock writes. Only the low address bits take part in the match. A sequence that breaks off silently falls back to read array and starts nothing. While the embedded controller reports busy, writes are ignored. The one exception is the erase-suspend byte during a sector erase, which is forwarded to the erase engine as its own strobe. A failure reported by the controller latches a flag. Only the reset command clears that flag.

In identification mode a read port returns the identification and protect-status bytes from the low read-address bits.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After rst_ni is released, mode_o is 0 (read array), fail_o is 0 and every strobe is 0. Mode codes are: 0 read, 1 identification, 2 query, 3 program, 4 chip erase, 5 sector erase.
- R2: A sequence begins with AA at address 555 followed by 55 at address 2AA. Only address bits [10:0] are compared, so the upper address bits have no effect on the match.
- R3: AA/555, 55/2AA, 90/555 enters mode 1. In mode 1, id_data_o shows one of three values selected by rd_addr_i[7:0]: MFR_ID for 00, DEV_ID for 01, and for 02 the protect bit of the sector given by rd_addr_i[18:16] (00 or 01). Every other offset, and every other mode, gives 00.
- R4: AA/555, 55/2AA, A0/555 sets mode 3. The next write pulses prog_go_o one clock after that write, with op_addr_o and op_data_o equal to the write's address and data.
- R5: AA/555, 55/2AA, 80/555, AA/555, 55/2AA followed by 10/555 pulses chip_go_o and sets mode 4. If the last write is 30 at any address instead, it pulses sect_go_o with op_addr_o equal to that address and sets mode 5. While susp_i is high, the 80 write does not arm an erase.
- R6: A write of F0 at any address returns mode 0 from identification, from query, from a partial sequence and from an armed program, without any strobe.
- R7: 98 at address 55 enters mode 2 from read or from identification. In mode 2 every write other than F0 leaves the mode unchanged.
- R8: A write that does not match the next expected cycle drops the partial sequence and leaves mode 0 without any strobe. A later command must start again from the first unlock write.
- R9: While busy_i is high, writes start nothing and F0 has no effect. B0 during a sector erase pulses susp_o. When busy_i falls after a start, the mode returns to 0.
- R10: A one-clock fail_i pulse sets fail_o. While fail_o is set, the mode holds through a falling busy_i and every write except F0 is ignored. F0 clears fail_o and returns mode 0.
- R11: With susp_i high, busy_i low and no sequence pending, a single 30 write pulses resume_o and sets mode 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | One-clock bus write strobe |
| addr_i | input | 19 | Write address |
| data_i | input | 8 | Write data |
| busy_i | input | 1 | Embedded operation running |
| fail_i | input | 1 | Embedded operation failure pulse |
| susp_i | input | 1 | Erase currently suspended |
| rd_addr_i | input | 19 | Read address for identification data |
| sect_prot_i | input | 8 | Per-sector protect bits |
| mode_o | output | 3 | Current mode code |
| prog_go_o | output | 1 | Program start strobe |
| chip_go_o | output | 1 | Chip erase start strobe |
| sect_go_o | output | 1 | Sector erase start strobe |
| susp_o | output | 1 | Erase suspend strobe |
| resume_o | output | 1 | Erase resume strobe |
| op_addr_o | output | 19 | Captured address of the last start |
| op_data_o | output | 8 | Captured data of the last start |
| fail_o | output | 1 | Failure flag |
| id_data_o | output | 8 | Identification read data |

## Verification
Some properties are checked on every cycle. At most one strobe fires at a time. No start or resume strobe follows a busy cycle. The failure flag stays set until a reset write. The mode changes only after a write or a falling busy. The program strobe carries the data that was just written.

Other behaviour shows only in the bench's scenarios. These cover whole-sequence recognition, the effect of high address bits, aborts at each step, the identification contents and the suspend and resume flows. The bench runs directed cases and a seeded random write stream against a reference model.

// File: rtl/flash_dec_pkg.sv
package flash_dec_pkg;

  typedef enum logic [2:0] {
    MD_READ   = 3'd0,
    MD_ID     = 3'd1,
    MD_QUERY  = 3'd2,
    MD_PROG   = 3'd3,
    MD_CERASE = 3'd4,
    MD_SERASE = 3'd5
  } mode_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PARM, SQ_ERS3, SQ_ERS4, SQ_ERS5, SQ_RUN
  } seq_e;

  localparam logic [7:0] CB_UNL1  = 8'hAA;
  localparam logic [7:0] CB_UNL2  = 8'h55;
  localparam logic [7:0] CB_IDENT = 8'h90;
  localparam logic [7:0] CB_PROG  = 8'hA0;
  localparam logic [7:0] CB_ERASE = 8'h80;
  localparam logic [7:0] CB_CHIP  = 8'h10;
  localparam logic [7:0] CB_SECT  = 8'h30;
  localparam logic [7:0] CB_RST   = 8'hF0;
  localparam logic [7:0] CB_QUERY = 8'h98;
  localparam logic [7:0] CB_SUSP  = 8'hB0;
  localparam logic [7:0] CB_RESUM = 8'h30;

  localparam int unsigned KA_555 = 'h555;
  localparam int unsigned KA_2AA = 'h2AA;
  localparam int unsigned KA_055 = 'h055;

  typedef struct packed {
    logic unl1;
    logic unl2;
    logic ident;
    logic prog;
    logic erase;
    logic chip;
    logic sect;
    logic rst;
    logic query;
    logic susp;
    logic resum;
  } hit_t;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_dec_pkg::*;
#(
  parameter int AW = 19,
  parameter int CW = 11
) (
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output hit_t          hit_o
);
  localparam logic [CW-1:0] K555 = CW'(KA_555);
  localparam logic [CW-1:0] K2AA = CW'(KA_2AA);
  localparam logic [CW-1:0] K055 = CW'(KA_055);

  logic [CW-1:0] lo;
  logic a555, a2aa, a055;

  assign lo   = addr_i[CW-1:0];
  assign a555 = (lo == K555);
  assign a2aa = (lo == K2AA);
  assign a055 = (lo == K055);

  always_comb begin
    hit_o       = '0;
    hit_o.unl1  = a555 && (data_i == CB_UNL1);
    hit_o.unl2  = a2aa && (data_i == CB_UNL2);
    hit_o.ident = a555 && (data_i == CB_IDENT);
    hit_o.prog  = a555 && (data_i == CB_PROG);
    hit_o.erase = a555 && (data_i == CB_ERASE);
    hit_o.chip  = a555 && (data_i == CB_CHIP);
    hit_o.sect  = (data_i == CB_SECT);
    hit_o.rst   = (data_i == CB_RST);
    hit_o.query = a055 && (data_i == CB_QUERY);
    hit_o.susp  = (data_i == CB_SUSP);
    hit_o.resum = (data_i == CB_RESUM);
  end
endmodule

// File: rtl/flash_id_read.sv
module flash_id_read
  import flash_dec_pkg::*;
#(
  parameter int          AW     = 19,
  parameter int          SW     = 3,
  parameter logic [7:0]  MFR_ID = 8'h5A,
  parameter logic [7:0]  DEV_ID = 8'hC3
) (
  input  mode_e              mode_i,
  input  logic [AW-1:0]      rd_addr_i,
  input  logic [(1<<SW)-1:0] prot_i,
  output logic [7:0]         id_data_o
);
  logic [SW-1:0] sect;
  logic [7:0]    ofs;

  assign sect = rd_addr_i[AW-1 -: SW];
  assign ofs  = rd_addr_i[7:0];

  always_comb begin
    id_data_o = 8'h00;
    if (mode_i == MD_ID) begin
      unique case (ofs)
        8'h00:   id_data_o = MFR_ID;
        8'h01:   id_data_o = DEV_ID;
        8'h02:   id_data_o = {7'b0, prot_i[sect]};
        default: id_data_o = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_dec_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  input  hit_t          hit_i,
  input  logic          busy_i,
  input  logic          fail_i,
  input  logic          susp_i,
  output mode_e         mode_o,
  output logic          prog_go_o,
  output logic          chip_go_o,
  output logic          sect_go_o,
  output logic          susp_o,
  output logic          resume_o,
  output logic [AW-1:0] op_addr_o,
  output logic [7:0]    op_data_o,
  output logic          fail_o
);
  mode_e         mode_q;
  seq_e          seq_q;
  logic          fail_q, busy_q, busy_fall;
  logic          pg_q, cg_q, sg_q, su_q, rs_q;
  logic [AW-1:0] op_addr_q;
  logic [7:0]    op_data_q;

  assign busy_fall = busy_q && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= MD_READ;
      seq_q     <= SQ_IDLE;
      fail_q    <= 1'b0;
      busy_q    <= 1'b0;
      pg_q      <= 1'b0;
      cg_q      <= 1'b0;
      sg_q      <= 1'b0;
      su_q      <= 1'b0;
      rs_q      <= 1'b0;
      op_addr_q <= '0;
      op_data_q <= '0;
    end else begin
      busy_q <= busy_i;
      pg_q   <= 1'b0;
      cg_q   <= 1'b0;
      sg_q   <= 1'b0;
      su_q   <= 1'b0;
      rs_q   <= 1'b0;
      // running operation finished cleanly
      if (busy_fall && !fail_q && !fail_i && seq_q == SQ_RUN) begin
        mode_q <= MD_READ;
        seq_q  <= SQ_IDLE;
      end
      if (wr_i) begin
        if (fail_q) begin
          if (hit_i.rst) begin
            fail_q <= 1'b0;
            mode_q <= MD_READ;
            seq_q  <= SQ_IDLE;
          end
        end else if (busy_i) begin
          if (hit_i.susp && mode_q == MD_SERASE) su_q <= 1'b1;
        end else if (mode_q == MD_QUERY) begin
          if (hit_i.rst) mode_q <= MD_READ;
        end else if (mode_q == MD_ID) begin
          if (hit_i.rst)        mode_q <= MD_READ;
          else if (hit_i.query) mode_q <= MD_QUERY;
        end else if (seq_q == SQ_RUN) begin
          // start issued, controller not yet busy
        end else if (hit_i.rst) begin
          mode_q <= MD_READ;
          seq_q  <= SQ_IDLE;
        end else begin
          unique case (seq_q)
            SQ_IDLE: begin
              if (hit_i.unl1)       seq_q  <= SQ_UNL1;
              else if (hit_i.query) mode_q <= MD_QUERY;
              else if (hit_i.resum && susp_i) begin
                rs_q   <= 1'b1;
                mode_q <= MD_SERASE;
                seq_q  <= SQ_RUN;
              end
            end
            SQ_UNL1: seq_q <= hit_i.unl2 ? SQ_UNL2 : SQ_IDLE;
            SQ_UNL2: begin
              if (hit_i.ident) begin
                mode_q <= MD_ID;
                seq_q  <= SQ_IDLE;
              end else if (hit_i.prog) begin
                mode_q <= MD_PROG;
                seq_q  <= SQ_PARM;
              end else if (hit_i.erase && !susp_i) begin
                seq_q  <= SQ_ERS3;
              end else begin
                seq_q  <= SQ_IDLE;
              end
            end
            SQ_PARM: begin
              pg_q      <= 1'b1;
              op_addr_q <= addr_i;
              op_data_q <= data_i;
              seq_q     <= SQ_RUN;
            end
            SQ_ERS3: seq_q <= hit_i.unl1 ? SQ_ERS4 : SQ_IDLE;
            SQ_ERS4: seq_q <= hit_i.unl2 ? SQ_ERS5 : SQ_IDLE;
            SQ_ERS5: begin
              if (hit_i.chip) begin
                cg_q      <= 1'b1;
                op_addr_q <= addr_i;
                op_data_q <= data_i;
                mode_q    <= MD_CERASE;
                seq_q     <= SQ_RUN;
              end else if (hit_i.sect) begin
                sg_q      <= 1'b1;
                op_addr_q <= addr_i;
                op_data_q <= data_i;
                mode_q    <= MD_SERASE;
                seq_q     <= SQ_RUN;
              end else begin
                seq_q     <= SQ_IDLE;
              end
            end
            default: seq_q <= SQ_IDLE;
          endcase
        end
      end
      if (fail_i) fail_q <= 1'b1;
    end
  end

  assign mode_o    = mode_q;
  assign prog_go_o = pg_q;
  assign chip_go_o = cg_q;
  assign sect_go_o = sg_q;
  assign susp_o    = su_q;
  assign resume_o  = rs_q;
  assign op_addr_o = op_addr_q;
  assign op_data_o = op_data_q;
  assign fail_o    = fail_q;

  a_r5_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pg_q, cg_q, sg_q, su_q, rs_q}));

  a_r9_busy_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !fail_q) |=> !(pg_q || cg_q || sg_q || rs_q));

  a_r10_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && !(wr_i && hit_i.rst)) |=> fail_q);

  a_r4_prog_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pg_q |-> ($past(wr_i) && op_data_q == $past(data_i) && op_addr_q == $past(addr_i)));

  a_r8_mode_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q)) |-> ($past(wr_i) || $past(busy_fall)));
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_dec_pkg::*;
#(
  parameter int         AW     = 19,
  parameter int         CW     = 11,
  parameter int         SW     = 3,
  parameter logic [7:0] MFR_ID = 8'h5A,
  parameter logic [7:0] DEV_ID = 8'hC3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [7:0]           data_i,
  input  logic                 busy_i,
  input  logic                 fail_i,
  input  logic                 susp_i,
  input  logic [AW-1:0]        rd_addr_i,
  input  logic [(1<<SW)-1:0]   sect_prot_i,
  output logic [2:0]           mode_o,
  output logic                 prog_go_o,
  output logic                 chip_go_o,
  output logic                 sect_go_o,
  output logic                 susp_o,
  output logic                 resume_o,
  output logic [AW-1:0]        op_addr_o,
  output logic [7:0]           op_data_o,
  output logic                 fail_o,
  output logic [7:0]           id_data_o
);
  hit_t  hit;
  mode_e mode;

  flash_cmd_match #(.AW(AW), .CW(CW)) u_match (
    .addr_i (addr_i),
    .data_i (data_i),
    .hit_o  (hit)
  );

  flash_seq_fsm #(.AW(AW)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .hit_i     (hit),
    .busy_i    (busy_i),
    .fail_i    (fail_i),
    .susp_i    (susp_i),
    .mode_o    (mode),
    .prog_go_o (prog_go_o),
    .chip_go_o (chip_go_o),
    .sect_go_o (sect_go_o),
    .susp_o    (susp_o),
    .resume_o  (resume_o),
    .op_addr_o (op_addr_o),
    .op_data_o (op_data_o),
    .fail_o    (fail_o)
  );

  flash_id_read #(.AW(AW), .SW(SW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)) u_id (
    .mode_i    (mode),
    .rd_addr_i (rd_addr_i),
    .prot_i    (sect_prot_i),
    .id_data_o (id_data_o)
  );

  assign mode_o = mode;
endmodule

// File: tb/tb_flash_cmd_decoder.sv
module tb_flash_cmd_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  data = '0;
  logic        busy = 1'b0, fail_p = 1'b0, susp = 1'b0;
  logic [18:0] rd_addr = '0;
  logic [7:0]  prot = 8'b1010_0110;
  logic [2:0]  mode;
  logic        pg, cg, sg, su, rs, fl;
  logic [18:0] op_addr;
  logic [7:0]  op_data, id_data;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  int m_mode = 0, m_seq = 0;
  bit m_fail = 0, m_busy = 0;
  bit e_pg, e_cg, e_sg, e_su, e_rs;
  logic [18:0] e_addr = '0;
  logic [7:0]  e_data = '0;

  localparam int Q_IDLE = 0, Q_U1 = 1, Q_U2 = 2, Q_ARM = 3, Q_E3 = 4, Q_E4 = 5, Q_E5 = 6, Q_RUN = 7;

  flash_cmd_decoder dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .data_i(data),
    .busy_i(busy), .fail_i(fail_p), .susp_i(susp), .rd_addr_i(rd_addr),
    .sect_prot_i(prot), .mode_o(mode), .prog_go_o(pg), .chip_go_o(cg),
    .sect_go_o(sg), .susp_o(su), .resume_o(rs), .op_addr_o(op_addr),
    .op_data_o(op_data), .fail_o(fl), .id_data_o(id_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit lo_is(input logic [18:0] a, input int v);
    return a[10:0] == 11'(v);
  endfunction

  task automatic model_wr(input logic [18:0] a, input logic [7:0] d);
    e_pg = 0; e_cg = 0; e_sg = 0; e_su = 0; e_rs = 0;
    if (m_fail) begin
      if (d == 8'hF0) begin m_fail = 0; m_mode = 0; m_seq = Q_IDLE; end
    end else if (busy) begin
      if (d == 8'hB0 && m_mode == 5) e_su = 1;
    end else if (m_mode == 2) begin
      if (d == 8'hF0) m_mode = 0;
    end else if (m_mode == 1) begin
      if (d == 8'hF0) m_mode = 0;
      else if (d == 8'h98 && lo_is(a, 'h55)) m_mode = 2;
    end else if (m_seq == Q_RUN) begin
    end else if (d == 8'hF0) begin
      m_mode = 0; m_seq = Q_IDLE;
    end else begin
      case (m_seq)
        Q_IDLE: if (d == 8'hAA && lo_is(a, 'h555)) m_seq = Q_U1;
                else if (d == 8'h98 && lo_is(a, 'h55)) m_mode = 2;
                else if (d == 8'h30 && susp) begin e_rs = 1; m_mode = 5; m_seq = Q_RUN; end
        Q_U1:   m_seq = (d == 8'h55 && lo_is(a, 'h2AA)) ? Q_U2 : Q_IDLE;
        Q_U2: begin
          m_seq = Q_IDLE;
          if (lo_is(a, 'h555) && d == 8'h90) m_mode = 1;
          else if (lo_is(a, 'h555) && d == 8'hA0) begin m_mode = 3; m_seq = Q_ARM; end
          else if (lo_is(a, 'h555) && d == 8'h80 && !susp) m_seq = Q_E3;
        end
        Q_ARM: begin e_pg = 1; e_addr = a; e_data = d; m_seq = Q_RUN; end
        Q_E3:  m_seq = (d == 8'hAA && lo_is(a, 'h555)) ? Q_E4 : Q_IDLE;
        Q_E4:  m_seq = (d == 8'h55 && lo_is(a, 'h2AA)) ? Q_E5 : Q_IDLE;
        Q_E5: begin
          if (d == 8'h10 && lo_is(a, 'h555)) begin e_cg = 1; e_addr = a; e_data = d; m_mode = 4; m_seq = Q_RUN; end
          else if (d == 8'h30) begin e_sg = 1; e_addr = a; e_data = d; m_mode = 5; m_seq = Q_RUN; end
          else m_seq = Q_IDLE;
        end
        default: m_seq = Q_IDLE;
      endcase
    end
  endtask

  task automatic do_wr(input logic [18:0] a, input logic [7:0] d, input string req);
    @(negedge clk);
    wr = 1; addr = a; data = d;
    model_wr(a, d);
    @(posedge clk); #1;
    chk({req, " mode"}, mode, m_mode);
    chk({req, " prog_go"}, pg, e_pg);
    chk({req, " chip_go"}, cg, e_cg);
    chk({req, " sect_go"}, sg, e_sg);
    chk({req, " susp"}, su, e_su);
    chk({req, " resume"}, rs, e_rs);
    chk({req, " fail"}, fl, m_fail);
    if (e_pg || e_cg || e_sg) begin
      chk({req, " op_addr"}, op_addr, e_addr);
      chk({req, " op_data"}, op_data, e_data);
    end
    @(negedge clk);
    wr = 0;
  endtask

  task automatic set_busy(input bit v, input string req);
    @(negedge clk);
    busy = v;
    if (m_busy && !v && !m_fail && m_seq == Q_RUN) begin m_mode = 0; m_seq = Q_IDLE; end
    m_busy = v;
    @(posedge clk); #1;
    chk({req, " mode after busy"}, mode, m_mode);
  endtask

  task automatic pulse_fail();
    @(negedge clk); fail_p = 1; m_fail = 1;
    @(posedge clk); #1;
    chk("R10 fail set", fl, 1);
    @(negedge clk); fail_p = 0;
  endtask

  task automatic unlock(input logic [18:0] hi, input string req);
    do_wr(hi | 19'h555, 8'hAA, req);
    do_wr(hi | 19'h2AA, 8'h55, req);
  endtask

  task automatic id_rd(input logic [18:0] a, input int exp, input string req);
    @(negedge clk); rd_addr = a; #1;
    chk(req, id_data, exp);
  endtask

  task automatic rand_wr();
    logic [18:0] ra;
    logic [7:0] rd;
    ra = 19'($urandom);
    case ($urandom % 12)
      0, 1: begin ra = {ra[18:11], 11'h555}; rd = 8'hAA; end
      2, 3: begin ra = {ra[18:11], 11'h2AA}; rd = 8'h55; end
      4:    begin ra = {ra[18:11], 11'h555}; rd = 8'h90; end
      5:    begin ra = {ra[18:11], 11'h555}; rd = 8'hA0; end
      6:    begin ra = {ra[18:11], 11'h555}; rd = 8'h80; end
      7:    begin ra = {ra[18:11], 11'h555}; rd = 8'h10; end
      8:    rd = 8'h30;
      9:    rd = 8'hF0;
      10:   begin ra = {ra[18:11], 11'h055}; rd = 8'h98; end
      default: rd = 8'($urandom);
    endcase
    do_wr(ra, rd, "R8 random");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    // R1 reset state
    chk("R1 mode", mode, 0);
    chk("R1 fail", fl, 0);
    chk("R1 strobes", {pg, cg, sg, su, rs}, 0);

    // R2/R3 identification with high address bits set
    unlock(19'h7C000, "R2 unlock high bits");
    do_wr(19'h35555, 8'h90, "R3 enter id");
    chk("R3 id mode", mode, 1);
    id_rd(19'h00000, 8'h5A, "R3 mfr byte");
    id_rd(19'h00001, 8'hC3, "R3 dev byte");
    id_rd(19'h10002, 1, "R3 protect sector1");
    id_rd(19'h00002, 0, "R3 protect sector0");
    id_rd(19'h00007, 0, "R3 other offset");
    do_wr(19'h00555, 8'hAA, "R3 id ignores unlock");
    do_wr(19'h12345, 8'hF0, "R6 reset from id");
    id_rd(19'h00000, 0, "R3 id data outside mode");

    // R4 program, R9 busy blocks reset
    unlock('0, "R4");
    do_wr(19'h555, 8'hA0, "R4 arm");
    chk("R4 mode prog", mode, 3);
    do_wr(19'h4ABCD, 8'h3C, "R4 program data");
    set_busy(1, "R9");
    do_wr(19'h0, 8'hF0, "R9 reset ignored while busy");
    chk("R9 mode held", mode, 3);
    set_busy(0, "R9 busy fall");
    chk("R9 back to read", mode, 0);

    // R6 reset in armed program
    unlock('0, "R6");
    do_wr(19'h555, 8'hA0, "R6 arm");
    do_wr(19'h1, 8'hF0, "R6 abort arm");
    chk("R6 no program", mode, 0);

    // R5 chip erase
    unlock('0, "R5"); do_wr(19'h555, 8'h80, "R5");
    unlock('0, "R5"); do_wr(19'h555, 8'h10, "R5 chip erase");
    set_busy(1, "R5"); set_busy(0, "R5");
    // R5 sector erase, R9 suspend
    unlock('0, "R5"); do_wr(19'h555, 8'h80, "R5");
    unlock('0, "R5"); do_wr(19'h60000, 8'h30, "R5 sector erase");
    chk("R5 sector addr", op_addr, 19'h60000);
    set_busy(1, "R9");
    do_wr(19'h0, 8'hB0, "R9 suspend strobe");
    set_busy(0, "R9 suspend done");
    susp = 1;
    unlock('0, "R5 suspended"); do_wr(19'h555, 8'h80, "R5 suspended");
    unlock('0, "R5 suspended"); do_wr(19'h555, 8'h10, "R5 chip blocked when suspended");
    chk("R5 no chip start", mode, 0);
    do_wr(19'h0, 8'h30, "R11 resume");
    susp = 0;
    set_busy(1, "R11"); set_busy(0, "R11");

    // R7 query
    do_wr(19'h7F055, 8'h98, "R7 enter query");
    do_wr(19'h555, 8'hAA, "R7 ignored in query");
    do_wr(19'h555, 8'h90, "R7 ignored in query");
    chk("R7 still query", mode, 2);
    do_wr(19'h0, 8'hF0, "R7 leave query");

    // R8 mismatch
    do_wr(19'h555, 8'hAA, "R8");
    do_wr(19'h2AB, 8'h55, "R8 wrong addr");
    do_wr(19'h555, 8'h90, "R8 no id after abort");
    chk("R8 still read", mode, 0);

    // R10 failure
    unlock('0, "R10"); do_wr(19'h555, 8'hA0, "R10");
    do_wr(19'h22, 8'h00, "R10 start");
    set_busy(1, "R10"); pulse_fail(); set_busy(0, "R10 mode held on fail");
    chk("R10 mode held", mode, 3);
    unlock('0, "R10 ignored");
    do_wr(19'h0, 8'hF0, "R10 reset clears");
    chk("R10 cleared", fl, 0);

    // random stream
    for (int i = 0; i < 600; i++) begin
      if ($urandom % 16 == 0) susp = ~susp;
      rand_wr();
      if (e_pg || e_cg || e_sg || e_rs) begin
        set_busy(1, "R9 random");
        if ($urandom % 3 == 0) do_wr(19'($urandom), 8'hB0, "R9 random busy write");
        if ($urandom % 4 == 0) pulse_fail();
        set_busy(0, "R9 random");
        if (m_fail) do_wr(19'($urandom), 8'hF0, "R10 random reset");
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule